// File: doc/BRIEF.md
# Lockstep Output Mismatch Logger

This block sits beside a device under test and a golden replica that share one clock and one stimulus source. On every rising edge it compares the two output buses. Any cycle in which they differ becomes a log record: a timestamp taken from a free-running cycle counter, the value seen on each bus, and a bitwise difference mask. Records queue in a small first-in first-out buffer that a host drains through a valid/ready port.

Detection never halts the test. A stimulus step index keeps looping through a fixed-length program no matter what is logged. As a result, one upset that travels through the target can produce a train of records over later cycles, and each of them is kept. If the buffer is full when a mismatch arrives, the record is dropped and a saturating overflow counter counts the loss.

A latch-up indication from the target's supply monitor passes through a synchroniser and sets a sticky alarm. While the alarm is set, the target supply enable is held off. Only an explicit host clear removes the alarm.

Top module: `lockstep_mismatch_logger`

## Requirements
- R1: When the two output buses are equal at a clock edge, no record is written and the overflow count does not change.
- R2: When the buses differ at an edge and the buffer has room, a record is present at the read port (rec_valid_o high) after that edge.
- R3: The record is 56 bits wide. Bits [55:24] hold the cycle number, bits [23:16] the target output, bits [15:8] the golden output, and bits [7:0] the XOR of the two.
- R4: The cycle number is 0 for the first edge after reset is released and rises by one on every edge. Consecutive mismatching cycles each produce their own record, carrying consecutive cycle numbers.
- R5: The stimulus step index stim_idx_o counts 0 to LOOP_LEN-1 (68 by default) and wraps to 0. Mismatches do not pause it or reset it.
- R6: The buffer holds 16 records and hands them out oldest first. A record is consumed at an edge where both rec_valid_o and rec_ready_i are high. While rec_ready_i is low, the head record and rec_valid_o stay stable.
- R7: A mismatch that arrives while the buffer holds 16 records is not written, and the overflow count rises by one. Fullness is judged by the occupancy before any read in the same cycle.
- R8: The 16-bit overflow count saturates at 65535.
- R9: The latch-up input passes through two synchroniser flip-flops. The alarm therefore rises after the third edge at which latchup_i is high, and supply_en_o is low whenever the alarm is set.
- R10: The alarm stays set after latchup_i falls until alarm_clr_i is sampled high. A clear is ignored while the synchronised latch-up is still high.
- R11: Reset leaves the buffer empty, the overflow count at 0, the alarm clear, the supply enabled and the step index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dut_out_i | input | 8 | Output bus of the device under test |
| ref_out_i | input | 8 | Output bus of the golden replica |
| stim_idx_o | output | 7 | Current step of the looping stimulus program |
| rec_valid_o | output | 1 | A record is available |
| rec_ready_i | input | 1 | Host accepts the head record |
| rec_data_o | output | 56 | Head record {cycle, target, golden, mask} |
| ovf_cnt_o | output | 16 | Saturating count of dropped records |
| latchup_i | input | 1 | Asynchronous latch-up indication |
| alarm_clr_i | input | 1 | Host clear of the latch-up alarm |
| alarm_o | output | 1 | Sticky latch-up alarm |
| supply_en_o | output | 1 | Target supply enable |

## Verification
Overflow saturation is the hardest state to reach. The buffer must first be filled, and the mismatch must then be held for more than 65535 cycles while the host leaves the read port idle. The bench does exactly that after an earlier fill-and-drain pass. That earlier pass also covers the case where a mismatch and a read meet on a full buffer, which must still drop the record. A second corner is a clear that arrives while the synchronised latch-up is still high. The bench holds latchup_i until both synchroniser stages are set and only then asserts the clear.

// File: rtl/lml_pkg.sv
package lml_pkg;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_CYC_W    = 32;
  localparam int unsigned DEF_DEPTH    = 16;
  localparam int unsigned DEF_OVF_W    = 16;
  localparam int unsigned DEF_LOOP_LEN = 68;
  localparam int unsigned DEF_SYNC     = 2;
endpackage

// File: rtl/lml_fifo.sv
module lml_fifo #(
  parameter int unsigned W     = 56,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  // fullness uses occupancy before this cycle's read
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/lml_alarm.sv
module lml_alarm #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latchup_i,
  input  logic clr_i,
  output logic alarm_o
);
  logic [STAGES-1:0] sync_q;
  logic              alarm_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= latchup_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], latchup_i};
      end
    end
  endgenerate

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 alarm_q <= 1'b0;
    else if (sync_q[STAGES-1])   alarm_q <= 1'b1;
    else if (clr_i)              alarm_q <= 1'b0;
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/lockstep_mismatch_logger.sv
module lockstep_mismatch_logger
  import lml_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned CYC_W    = DEF_CYC_W,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned OVF_W    = DEF_OVF_W,
  parameter int unsigned LOOP_LEN = DEF_LOOP_LEN,
  parameter int unsigned SYNC     = DEF_SYNC,
  localparam int unsigned STIM_W  = $clog2(LOOP_LEN),
  localparam int unsigned REC_W   = CYC_W + 3*DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dut_out_i,
  input  logic [DATA_W-1:0] ref_out_i,
  output logic [STIM_W-1:0] stim_idx_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [REC_W-1:0]  rec_data_o,
  output logic [OVF_W-1:0]  ovf_cnt_o,
  input  logic              latchup_i,
  input  logic              alarm_clr_i,
  output logic              alarm_o,
  output logic              supply_en_o
);
  logic [CYC_W-1:0]  cyc_q;
  logic [STIM_W-1:0] stim_q;
  logic [OVF_W-1:0]  ovf_q;
  logic [DATA_W-1:0] diff;
  logic              mismatch, fifo_full;
  logic [REC_W-1:0]  rec_in;

  assign diff     = dut_out_i ^ ref_out_i;
  assign mismatch = |diff;
  assign rec_in   = {cyc_q, dut_out_i, ref_out_i, diff};

  // free-running timestamp, wraps silently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + 1'b1;
  end

  // stimulus program step, never held by detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   stim_q <= '0;
    else if (stim_q == STIM_W'(LOOP_LEN - 1))      stim_q <= '0;
    else                                           stim_q <= stim_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ovf_q <= '0;
    else if (mismatch && fifo_full && !(&ovf_q))   ovf_q <= ovf_q + 1'b1;
  end

  lml_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mismatch),
    .data_i  (rec_in),
    .full_o  (fifo_full),
    .valid_o (rec_valid_o),
    .ready_i (rec_ready_i),
    .data_o  (rec_data_o)
  );

  lml_alarm #(.STAGES(SYNC)) u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latchup_i (latchup_i),
    .clr_i     (alarm_clr_i),
    .alarm_o   (alarm_o)
  );

  assign supply_en_o = !alarm_o;
  assign stim_idx_o  = stim_q;
  assign ovf_cnt_o   = ovf_q;
endmodule

// File: rtl/lml_checker.sv
module lml_checker #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVF_W    = 16,
  parameter int unsigned REC_W    = 56,
  parameter int unsigned STIM_W   = 7,
  parameter int unsigned LOOP_LEN = 68,
  parameter int unsigned SYNC     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] dut_out_i,
  input logic [DATA_W-1:0] ref_out_i,
  input logic [STIM_W-1:0] stim_idx_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [REC_W-1:0]  rec_data_o,
  input logic [OVF_W-1:0]  ovf_cnt_o,
  input logic              latchup_i,
  input logic              alarm_clr_i,
  input logic              alarm_o,
  input logic              full_i
);
  AST_PUSH_ON_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dut_out_i != ref_out_i) && !full_i |=> rec_valid_o); // R2

  AST_HEAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_data_o)); // R6

  AST_OVF_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((dut_out_i != ref_out_i) && full_i) |=> $stable(ovf_cnt_o)); // R7

  AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ovf_cnt_o) |=> (&ovf_cnt_o)); // R8

  AST_STIM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stim_idx_o != STIM_W'(LOOP_LEN - 1) |=> stim_idx_o == $past(stim_idx_o) + 1'b1); // R5

  AST_ALARM_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(latchup_i, SYNC + 1)); // R9

  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !alarm_clr_i |=> alarm_o); // R10
endmodule

bind lockstep_mismatch_logger lml_checker #(
  .DATA_W(DATA_W), .OVF_W(OVF_W), .REC_W(REC_W),
  .STIM_W(STIM_W), .LOOP_LEN(LOOP_LEN), .SYNC(SYNC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dut_out_i   (dut_out_i),
  .ref_out_i   (ref_out_i),
  .stim_idx_o  (stim_idx_o),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_data_o  (rec_data_o),
  .ovf_cnt_o   (ovf_cnt_o),
  .latchup_i   (latchup_i),
  .alarm_clr_i (alarm_clr_i),
  .alarm_o     (alarm_o),
  .full_i      (fifo_full)
);

// File: tb/tb_lockstep_mismatch_logger.sv
module tb_lockstep_mismatch_logger;
  localparam int LOOP = 68;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dut_v = '0, ref_v = '0;
  logic [6:0]  stim;
  logic        valid, ready = 1'b0;
  logic [55:0] data;
  logic [15:0] ovf;
  logic        latch = 1'b0, clr = 1'b0, alarm, sup;

  int unsigned ec = 0;
  int total = 0, bad = 0;
  logic [55:0] exp_q [$];

  always #4 clk = ~clk;

  lockstep_mismatch_logger dut (
    .clk_i(clk), .rst_ni(rst_n), .dut_out_i(dut_v), .ref_out_i(ref_v),
    .stim_idx_o(stim), .rec_valid_o(valid), .rec_ready_i(ready),
    .rec_data_o(data), .ovf_cnt_o(ovf), .latchup_i(latch),
    .alarm_clr_i(clr), .alarm_o(alarm), .supply_en_o(sup)
  );

  task automatic tick();
    @(posedge clk);
    if (rst_n) ec++;
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] mk(input int unsigned c, input logic [7:0] a, input logic [7:0] b);
    return {c[31:0], a, b, a ^ b};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; dut_v = '0; ref_v = '0; ready = 1'b0; latch = 1'b0; clr = 1'b0;
    exp_q.delete();
    repeat (3) tick();
    rst_n = 1'b1;
    ec = 0;
  endtask

  task automatic mis(input logic [7:0] a, input logic [7:0] b, input bit log_it);
    dut_v = a; ref_v = b;
    if (log_it) exp_q.push_back(mk(ec, a, b));
    tick();
    dut_v = '0; ref_v = '0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [55:0] e;
      e = exp_q.pop_front();
      chk(valid === 1'b1, req, valid, 1);
      chk(data === e, req, data, e);
      ready = 1'b1;
      tick();
      ready = 1'b0;
    end
    chk(valid === 1'b0, req, valid, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(valid === 1'b0, "R11", valid, 0);
    chk(ovf === 16'd0, "R11", ovf, 0);
    chk(alarm === 1'b0, "R11", alarm, 0);
    chk(sup === 1'b1, "R11", sup, 1);
    chk(stim === 7'd0, "R11", stim, 0);
  endtask

  task automatic t_equal();
    for (int i = 0; i < 6; i++) begin
      dut_v = 8'(i * 37 + 1); ref_v = dut_v;
      tick();
    end
    dut_v = '0; ref_v = '0;
    chk(valid === 1'b0, "R1 no record", valid, 0);
    chk(ovf === 16'd0, "R1 ovf", ovf, 0);
  endtask

  task automatic t_single();
    mis(8'hA5, 8'h25, 1'b1);
    chk(valid === 1'b1, "R2 valid", valid, 1);
    chk(data[7:0] === 8'h80, "R3 mask", data[7:0], 8'h80);
    chk(data[23:16] === 8'hA5 && data[15:8] === 8'h25, "R3 fields", data[23:8], 16'hA525);
    repeat (2) tick();
    chk(valid === 1'b1 && data === exp_q[0], "R6 hold", data, exp_q[0]);
    drain("R3 single");
  endtask

  task automatic t_burst();
    int unsigned s0;
    s0 = ec;
    mis(8'h01, 8'h00, 1'b1);
    mis(8'hFF, 8'h0F, 1'b1);
    mis(8'h3C, 8'hC3, 1'b1);
    chk(stim === 7'((s0 + 3) % LOOP), "R5 running", stim, (s0 + 3) % LOOP);
    chk(exp_q[2][55:24] - exp_q[0][55:24] == 2, "R4 consecutive", exp_q[2][55:24], exp_q[0][55:24] + 2);
    drain("R4 burst");
  endtask

  task automatic t_stim_wrap();
    while (stim != 7'(LOOP - 1)) tick();
    chk(stim === 7'(ec % LOOP), "R5 index", stim, ec % LOOP);
    mis(8'h10, 8'h11, 1'b1);
    chk(stim === 7'd0, "R5 wrap", stim, 0);
    drain("R5 rec");
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) mis(8'(i), 8'(i) ^ 8'hFF, 1'b1);
    for (int i = 0; i < 5; i++) mis(8'h77, 8'h66, 1'b0);
    chk(ovf === 16'd5, "R7 ovf count", ovf, 5);
    chk(data === exp_q[0], "R6 oldest", data, exp_q[0]);
    // full with a read in the same cycle: still dropped
    ready = 1'b1;
    mis(8'h55, 8'hAA, 1'b0);
    ready = 1'b0;
    void'(exp_q.pop_front());
    chk(ovf === 16'd6, "R7 full+read", ovf, 6);
    drain("R6 order");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 16; i++) mis(8'h01, 8'h02, 1'b0);
    dut_v = 8'h0F; ref_v = 8'hF0;
    repeat (65540) tick();
    dut_v = '0; ref_v = '0;
    chk(ovf === 16'hFFFF, "R8 saturate", ovf, 16'hFFFF);
    tick();
    chk(ovf === 16'hFFFF, "R8 hold", ovf, 16'hFFFF);
  endtask

  task automatic t_alarm();
    latch = 1'b1;
    repeat (2) tick();
    chk(alarm === 1'b0 && sup === 1'b1, "R9 sync delay", alarm, 0);
    tick();
    chk(alarm === 1'b1, "R9 alarm", alarm, 1);
    chk(sup === 1'b0, "R9 supply off", sup, 0);
    latch = 1'b0;
    repeat (4) tick();
    chk(alarm === 1'b1, "R10 sticky", alarm, 1);
    latch = 1'b1;
    repeat (3) tick();
    clr = 1'b1; tick(); clr = 1'b0;
    chk(alarm === 1'b1, "R10 clear ignored", alarm, 1);
    latch = 1'b0;
    repeat (2) tick();
    clr = 1'b1; tick(); clr = 1'b0;
    chk(alarm === 1'b0 && sup === 1'b1, "R10 cleared", alarm, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_equal();
    t_single();
    t_burst();
    t_stim_wrap();
    t_full();
    t_alarm();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule